// File: doc/BRIEF.md
# Shared PCI Interrupt Line Router

This block connects four level-sensitive, wire-OR'd PCI interrupt lines to sixteen request inputs of a legacy interrupt controller. Each of the four lines has an 8-bit route byte. The byte either names the controller input that the line drives or, if its value is sixteen or greater, leaves the line unconnected. An output is high while at least one line that is high is routed to it. Several lines can share one output.

The block keeps a 4x16 level map, one bit for each pair of line and target. While the routing stays the same, a level change on a line updates only that line's bit under its current target. Any write to a route byte discards the whole map. The map is then rebuilt from the levels present on the lines at that moment, under the new routing. Outputs are registered and follow the clock edge that sampled the change.

Two small helpers sit beside the router. The first is a slot swizzle that turns a device's interrupt pin and device/function number into a line index. The second is a route query that reports, for a given pin, whether that pin is routed and to which output.

Top module: `pirq_router`

## Requirements
- R1: After reset, every route byte reads 0x80, all sixteen outputs are low, and the route query reports disabled.
- R2: A write with `reg_we_i` high stores `reg_wdata_i` unchanged into the route byte chosen by `reg_idx_i`. Index 0 to 3 selects lines A to D in that order. `reg_rdata_o` returns the stored byte for the current index.
- R3: A route byte below 16 connects its line to output `irq_o[value]`. The output reflects the line's level as sampled at a clock edge, starting at that edge.
- R4: A route byte of 16 or greater disconnects its line. Level changes on that line leave every output unchanged.
- R5: An output is the OR of all lines currently routed to it. It stays high while any one of them is high.
- R6: A route write rebuilds all outputs at the write edge from the levels sampled at that edge under the new routing. A line that is already high appears on its new target, and its old target drops unless another routed line holds it.
- R7: `swz_pirq_o` equals (`swz_pin_i` + `swz_devfn_i[7:3]` - 1) mod 4, where pin 0 to 3 stands for INTA to INTD.
- R8: For pin `qry_pin_i`, `qry_en_o` is high and `qry_irq_o` holds the value exactly when that pin's route byte is below 16. Otherwise `qry_en_o` is low and `qry_irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pirq_i | input | 4 | Shared interrupt line levels, bit 0 = line A |
| reg_we_i | input | 1 | Route byte write strobe |
| reg_idx_i | input | 2 | Route byte index, 0..3 = A..D |
| reg_wdata_i | input | 8 | Route byte write data |
| reg_rdata_o | output | 8 | Route byte at `reg_idx_i` |
| irq_o | output | 16 | Controller request lines |
| swz_devfn_i | input | 8 | Device/function number for the swizzle |
| swz_pin_i | input | 2 | Device pin, 0..3 = INTA..INTD |
| swz_pirq_o | output | 2 | Line index chosen by the swizzle |
| qry_pin_i | input | 2 | Line whose route is queried |
| qry_en_o | output | 1 | Queried route is connected |
| qry_irq_o | output | 4 | Target of the queried route, 0 when disconnected |

## Verification
The assertions compare each output with the line levels at the previous edge, ORed over the lines whose stored route names that output. This comparison is only valid if the line levels stay steady around the edge. The bench therefore changes lines, strobes and indices only at the falling edge, and samples at the falling edge that follows. The readback property assumes the index stays put across a write. Random writes mix in-range targets with disabling values (16 to 31, 0x80, 0xFF), so every line is switched between connected and disconnected.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned ROUTE_W = 8;
  typedef logic [ROUTE_W-1:0] route_t;
  localparam route_t ROUTE_RST = 8'h80;
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = 4,
  parameter int unsigned NUM_IRQ  = 16,
  localparam int unsigned IDX_W = $clog2(NUM_PIRQ),
  localparam int unsigned IRQ_W = $clog2(NUM_IRQ)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [IDX_W-1:0]                   idx_i,
  input  route_t                             wdata_i,
  output route_t                             rdata_o,
  output logic [NUM_PIRQ-1:0][ROUTE_W-1:0]   route_o,
  output logic [NUM_PIRQ-1:0]                en_o,
  output logic [NUM_PIRQ-1:0][IRQ_W-1:0]     tgt_o,
  output logic [NUM_PIRQ-1:0]                en_d_o,
  output logic [NUM_PIRQ-1:0][IRQ_W-1:0]     tgt_d_o,
  input  logic [IDX_W-1:0]                   qry_pin_i,
  output logic                               qry_en_o,
  output logic [IRQ_W-1:0]                   qry_irq_o
);
  localparam route_t IRQ_LIM = route_t'(NUM_IRQ);

  route_t route_q [NUM_PIRQ];
  route_t route_d [NUM_PIRQ];

  for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_byte
    assign route_d[p] = (we_i && idx_i == IDX_W'(p)) ? wdata_i : route_q[p];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) route_q[p] <= ROUTE_RST;
      else         route_q[p] <= route_d[p];
    end

    assign route_o[p] = route_q[p];
    assign en_o[p]    = route_q[p] < IRQ_LIM;
    assign tgt_o[p]   = route_q[p][IRQ_W-1:0];
    assign en_d_o[p]  = route_d[p] < IRQ_LIM;
    assign tgt_d_o[p] = route_d[p][IRQ_W-1:0];
  end

  assign rdata_o   = route_q[idx_i];
  assign qry_en_o  = en_o[qry_pin_i];
  assign qry_irq_o = qry_en_o ? tgt_o[qry_pin_i] : '0;
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map #(
  parameter int unsigned NUM_PIRQ = 4,
  parameter int unsigned NUM_IRQ  = 16,
  localparam int unsigned IRQ_W = $clog2(NUM_IRQ),
  localparam int unsigned MAP_W = NUM_PIRQ * NUM_IRQ
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_PIRQ-1:0]            pirq_i,
  input  logic                           rebuild_i,
  input  logic [NUM_PIRQ-1:0]            en_i,
  input  logic [NUM_PIRQ-1:0][IRQ_W-1:0] tgt_i,
  input  logic [NUM_PIRQ-1:0]            en_d_i,
  input  logic [NUM_PIRQ-1:0][IRQ_W-1:0] tgt_d_i,
  output logic [NUM_IRQ-1:0]             irq_o
);
  logic [MAP_W-1:0]    map_q, map_d;
  logic [NUM_PIRQ-1:0] lvl_q;
  logic [NUM_IRQ-1:0]  irq_q, irq_d;

  for (genvar t = 0; t < NUM_IRQ; t++) begin : g_tgt
    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_line
      localparam int unsigned B = t * NUM_PIRQ + p;
      logic hit_new, hit_cur, moved;
      assign hit_new = en_d_i[p] && (tgt_d_i[p] == IRQ_W'(t));
      assign hit_cur = en_i[p] && (tgt_i[p] == IRQ_W'(t));
      assign moved   = pirq_i[p] != lvl_q[p];
      // rebuild wins over the incremental update
      assign map_d[B] = rebuild_i       ? (pirq_i[p] && hit_new) :
                        (moved && hit_cur) ? pirq_i[p] : map_q[B];
    end
    assign irq_d[t] = |map_d[t*NUM_PIRQ +: NUM_PIRQ];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q <= '0;
      lvl_q <= '0;
      irq_q <= '0;
    end else begin
      map_q <= map_d;
      lvl_q <= pirq_i;
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/pirq_swizzle.sv
module pirq_swizzle #(
  parameter int unsigned NUM_PIRQ = 4,
  localparam int unsigned PIN_W = $clog2(NUM_PIRQ)
) (
  input  logic [7:0]       devfn_i,
  input  logic [PIN_W-1:0] pin_i,
  output logic [PIN_W-1:0] pirq_o
);
  logic [4:0] dev;
  assign dev    = devfn_i[7:3];
  assign pirq_o = pin_i + dev[PIN_W-1:0] - PIN_W'(1);
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = 4,
  parameter int unsigned NUM_IRQ  = 16,
  localparam int unsigned IDX_W = $clog2(NUM_PIRQ),
  localparam int unsigned IRQ_W = $clog2(NUM_IRQ)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PIRQ-1:0] pirq_i,
  input  logic                reg_we_i,
  input  logic [IDX_W-1:0]    reg_idx_i,
  input  logic [7:0]          reg_wdata_i,
  output logic [7:0]          reg_rdata_o,
  output logic [NUM_IRQ-1:0]  irq_o,
  input  logic [7:0]          swz_devfn_i,
  input  logic [IDX_W-1:0]    swz_pin_i,
  output logic [IDX_W-1:0]    swz_pirq_o,
  input  logic [IDX_W-1:0]    qry_pin_i,
  output logic                qry_en_o,
  output logic [IRQ_W-1:0]    qry_irq_o
);
  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q;
  logic [NUM_PIRQ-1:0]              en, en_d;
  logic [NUM_PIRQ-1:0][IRQ_W-1:0]   tgt, tgt_d;

  pirq_route_regs #(.NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .idx_i     (reg_idx_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .route_o   (route_q),
    .en_o      (en),
    .tgt_o     (tgt),
    .en_d_o    (en_d),
    .tgt_d_o   (tgt_d),
    .qry_pin_i (qry_pin_i),
    .qry_en_o  (qry_en_o),
    .qry_irq_o (qry_irq_o)
  );

  pirq_level_map #(.NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pirq_i    (pirq_i),
    .rebuild_i (reg_we_i),
    .en_i      (en),
    .tgt_i     (tgt),
    .en_d_i    (en_d),
    .tgt_d_i   (tgt_d),
    .irq_o     (irq_o)
  );

  pirq_swizzle #(.NUM_PIRQ(NUM_PIRQ)) u_swz (
    .devfn_i (swz_devfn_i),
    .pin_i   (swz_pin_i),
    .pirq_o  (swz_pirq_o)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int unsigned NUM_PIRQ = 4,
  parameter int unsigned NUM_IRQ  = 16,
  localparam int unsigned IDX_W = $clog2(NUM_PIRQ),
  localparam int unsigned IRQ_W = $clog2(NUM_IRQ)
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [NUM_PIRQ-1:0]            pirq_i,
  input logic                           reg_we_i,
  input logic [IDX_W-1:0]               reg_idx_i,
  input logic [7:0]                     reg_wdata_i,
  input logic [7:0]                     reg_rdata_o,
  input logic [NUM_IRQ-1:0]             irq_o,
  input logic [7:0]                     swz_devfn_i,
  input logic [IDX_W-1:0]               swz_pin_i,
  input logic [IDX_W-1:0]               swz_pirq_o,
  input logic [IDX_W-1:0]               qry_pin_i,
  input logic                           qry_en_o,
  input logic [IRQ_W-1:0]               qry_irq_o,
  input logic [NUM_PIRQ-1:0][7:0]       route_q
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  logic [NUM_PIRQ-1:0] conn;
  for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_conn
    assign conn[p] = route_q[p] < 8'(NUM_IRQ);
  end

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_out
    logic [NUM_PIRQ-1:0] hit;
    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_hit
      assign hit[p] = conn[p] && (route_q[p][IRQ_W-1:0] == IRQ_W'(n));
    end
    // R3 R5 R6
    irq_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      live_q |-> (irq_o[n] == |($past(pirq_i) & hit)));
  end

  // R4
  unrouted_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conn == '0) |-> (irq_o == '0));

  // R2
  readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> ((reg_idx_i != $past(reg_idx_i)) || (reg_rdata_o == $past(reg_wdata_i))));

  // R7
  swizzle_slot1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swz_devfn_i[7:3] == 5'd1) |-> (swz_pirq_o == swz_pin_i));

  // R8
  query_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qry_pin_i == reg_idx_i) |-> (qry_en_o == (reg_rdata_o < 8'(NUM_IRQ))));

  // R8
  query_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qry_en_o |-> (qry_irq_o == '0));
endmodule

bind pirq_router pirq_router_chk #(.NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ)) u_chk (.*);

// File: tb/tb_pirq_router.sv
module tb_pirq_router;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  pirq_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_idx_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic [15:0] irq_o;
  logic [7:0]  swz_devfn_i = '0;
  logic [1:0]  swz_pin_i = '0;
  logic [1:0]  swz_pirq_o;
  logic [1:0]  qry_pin_i = '0;
  logic        qry_en_o;
  logic [3:0]  qry_irq_o;

  always #10 clk_i = ~clk_i;

  pirq_router dut (.*);

  logic [7:0] m_route [4];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_irq(logic [3:0] lvl);
    logic [15:0] r = '0;
    for (int p = 0; p < 4; p++)
      if (m_route[p] < 8'd16 && lvl[p]) r[m_route[p][3:0]] = 1'b1;
    return r;
  endfunction

  function automatic logic [1:0] exp_swz(logic [7:0] devfn, logic [1:0] pin);
    int v = (int'(pin) + int'(devfn[7:3]) + 3) % 4;
    return 2'(v);
  endfunction

  task automatic probe();
    swz_devfn_i = 8'($urandom);
    swz_pin_i   = 2'($urandom);
    qry_pin_i   = 2'($urandom);
    #1;
    chk("R7 swizzle", swz_pirq_o, exp_swz(swz_devfn_i, swz_pin_i));
    chk("R8 query en", qry_en_o, m_route[qry_pin_i] < 8'd16);
    chk("R8 query irq", qry_irq_o, (m_route[qry_pin_i] < 8'd16) ? m_route[qry_pin_i][3:0] : 4'd0);
  endtask

  // called at a falling edge; checks at the next falling edge
  task automatic step(string tag, bit we, logic [1:0] idx, logic [7:0] wd, logic [3:0] lvl);
    reg_we_i = we; reg_idx_i = idx; reg_wdata_i = wd; pirq_i = lvl;
    @(posedge clk_i);
    @(negedge clk_i);
    reg_we_i = 1'b0;
    if (we) m_route[idx] = wd;
    chk({tag, " irq"}, irq_o, exp_irq(lvl));
    chk("R2 readback", reg_rdata_o, m_route[idx]);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int p = 0; p < 4; p++) m_route[p] = 8'h80;
    repeat (3) @(negedge clk_i);
    chk("R1 reset irq", irq_o, 16'h0);
    for (int p = 0; p < 4; p++) begin
      reg_idx_i = 2'(p); qry_pin_i = 2'(p); #1;
      chk("R1 reset route", reg_rdata_o, 8'h80);
      chk("R1 reset query", qry_en_o, 1'b0);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4: unrouted lines toggle, no effect
    step("R4 unrouted high", 0, 0, 0, 4'hF);
    step("R4 unrouted low", 0, 0, 0, 4'h0);
    // R3: route A to 5
    step("R3 route A", 1, 0, 8'd5, 4'h0);
    step("R3 A high", 0, 0, 0, 4'h1);
    // R4: B unrouted toggles while A high
    step("R4 B toggle", 0, 1, 0, 4'h3);
    // R6: route B to 5 while B already high
    step("R6 route B live", 1, 1, 8'd5, 4'h3);
    // R5: A drops, B keeps irq5
    step("R5 OR hold", 0, 1, 0, 4'h2);
    // R6: move B to 15, old target drops
    step("R6 move B", 1, 1, 8'd15, 4'h2);
    // R4: disable B with 16
    step("R4 disable 16", 1, 1, 8'd16, 4'h2);
    step("R3 route D 0", 1, 3, 8'd0, 4'hA);
    step("R4 disable ff", 1, 3, 8'hFF, 4'hA);
    step("R2 write C 0x1f", 1, 2, 8'h1F, 4'h4);
    // R7 directed corners
    swz_devfn_i = 8'h00; swz_pin_i = 2'd0; #1;
    chk("R7 dev0 INTA", swz_pirq_o, 2'd3);
    swz_devfn_i = 8'h0F; swz_pin_i = 2'd3; #1;
    chk("R7 dev1 INTD", swz_pirq_o, 2'd3);
    swz_devfn_i = 8'hFF; swz_pin_i = 2'd2; #1;
    chk("R7 dev31 INTC", swz_pirq_o, 2'd0);
    probe();

    for (int i = 0; i < 400; i++) begin
      logic [7:0] wd;
      int sel = int'($urandom_range(0, 9));
      bit we = ($urandom_range(0, 3) == 0);
      if (sel < 6)      wd = 8'($urandom_range(0, 15));
      else if (sel < 8) wd = 8'($urandom_range(16, 31));
      else if (sel < 9) wd = 8'h80;
      else              wd = 8'hFF;
      step("R3 R5 R6 random", we, 2'($urandom), wd, 4'($urandom));
      probe();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule